// File: doc/BRIEF.md
# MII to RMII Transmit Bridge

This block sits between an Ethernet MAC that transmits four bits at a time and a PHY that takes two bits at a time on a reduced pin-count interface. Everything runs from the single 50 MHz reference clock that the PHY side already uses. The bridge derives the MAC's transmit clock from that reference and returns it on `mii_tx_clk`. On the rising edge of that clock it captures one nibble, and it then sends the nibble to the PHY as two dibits: bits [1:0] first, then bits [3:2].

A static rate input selects the line rate. At the fast rate (100 Mbps), each dibit lasts one reference cycle and the MAC clock runs at 25 MHz. At the slow rate (10 Mbps), each dibit is held for ten reference cycles and the MAC clock runs at 2.5 MHz. If the MAC flags a transmit error during a frame, the bridge replaces the rest of that frame with the constant dibit `01`. The substitution stops when the frame ends.

Top module: `mii_rmii_tx_bridge`

## Requirements
- R1: While `rst_n` is low at a rising reference-clock edge, the next state has `rmii_tx_en` = 0, `rmii_txd` = 00 and `mii_tx_clk` = 0. Reset is synchronous.
- R2: With `rate_10m` = 0, `mii_tx_clk` toggles on every reference edge, which gives a period of two reference cycles.
- R3: With `rate_10m` = 1, `mii_tx_clk` is high for 10 reference cycles and then low for 10. Each dibit on `rmii_txd` is held for 10 consecutive reference cycles.
- R4: The MII inputs are captured at the reference edge where `mii_tx_clk` rises. Starting at that same edge, `rmii_txd` carries captured bits [1:0] for one dibit slot and then bits [3:2] for one dibit slot.
- R5: At each capture edge, `rmii_tx_en` takes the captured `mii_tx_en` value. It does not change at any other edge.
- R6: While `rmii_tx_en` is 0, `rmii_txd` is 00.
- R7: A nibble captured with both `mii_tx_en` and `mii_tx_er` high is sent as `01`,`01`. Every later nibble of the same frame is also sent as `01`,`01`, whatever `mii_tx_er` is.
- R8: Error substitution ends at the first capture with `mii_tx_en` low. The next frame is sent from its own data.
- R9: A high `mii_tx_er` captured with `mii_tx_en` low has no effect on the outputs or on the following frame.
- R10: `rate_10m` = 1 selects 10 Mbps and 0 selects 100 Mbps. It may change only right after a capture edge while the line is idle, and the new rate applies from the following dibit slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_10m | input | 1 | 1 = 10 Mbps, 0 = 100 Mbps |
| mii_tx_en | input | 1 | MAC transmit enable |
| mii_txd | input | 4 | MAC transmit nibble |
| mii_tx_er | input | 1 | MAC transmit error |
| mii_tx_clk | output | 1 | Derived MAC transmit clock |
| rmii_tx_en | output | 1 | PHY transmit enable |
| rmii_txd | output | 2 | PHY transmit dibit |

## Verification
A nibble presented after one rising edge of `mii_tx_clk` is captured at the next rising edge. Its low dibit and enable appear in the register outputs right after that edge. Its high dibit follows one dibit slot later, which is one reference cycle at the fast rate and ten at the slow rate. The bench drives each nibble just after a capture edge. It then samples every reference cycle of the following period on falling edges, expecting the nibble captured at the start of that period. The expected values come from a small requirement-level model that carries the error flag from nibble to nibble.

// File: rtl/mii_rmii_pkg.sv
package mii_rmii_pkg;
  typedef logic [3:0] nibble_t;
  typedef logic [1:0] dibit_t;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  localparam dibit_t IDLE_DIBIT = 2'b00;
  localparam dibit_t ERR_DIBIT  = 2'b01;
endpackage

// File: rtl/tx_slot_timer.sv
module tx_slot_timer
  import mii_rmii_pkg::*;
#(
  parameter int SLOW_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow,
  output logic take_nibble,
  output logic next_half,
  output logic txclk_q
);
  localparam int CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  half_e         half_q;
  logic          slot_end;

  always_comb begin
    lim         = slow ? SLOW_LIM : '0;
    slot_end    = (cnt_q >= lim);
    take_nibble = slot_end && (half_q == HALF_HI);
    next_half   = slot_end && (half_q == HALF_LO);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      half_q  <= HALF_HI;
      txclk_q <= 1'b0;
    end else if (slot_end) begin
      cnt_q   <= '0;
      half_q  <= (half_q == HALF_HI) ? HALF_LO : HALF_HI;
      txclk_q <= (half_q == HALF_HI);
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tx_dibit_shaper.sv
module tx_dibit_shaper
  import mii_rmii_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    take_nibble,
  input  logic    next_half,
  input  logic    tx_en,
  input  nibble_t txd,
  input  logic    tx_er,
  output logic    out_en,
  output dibit_t  out_d
);
  logic   err_q;
  logic   err_n;
  dibit_t hi_q;
  dibit_t lo_n;
  dibit_t hi_n;

  always_comb begin
    err_n = tx_en && (err_q || tx_er);
    if (!tx_en) begin
      lo_n = IDLE_DIBIT;
      hi_n = IDLE_DIBIT;
    end else if (err_n) begin
      lo_n = ERR_DIBIT;
      hi_n = ERR_DIBIT;
    end else begin
      lo_n = txd[1:0];
      hi_n = txd[3:2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      hi_q   <= IDLE_DIBIT;
      out_en <= 1'b0;
      out_d  <= IDLE_DIBIT;
    end else if (take_nibble) begin
      err_q  <= err_n;
      hi_q   <= hi_n;
      out_en <= tx_en;
      out_d  <= lo_n;
    end else if (next_half) begin
      out_d <= hi_q;
    end
  end
endmodule

// File: rtl/mii_rmii_tx_bridge.sv
module mii_rmii_tx_bridge
  import mii_rmii_pkg::*;
#(
  parameter int SLOW_DIV = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rate_10m,
  input  logic       mii_tx_en,
  input  logic [3:0] mii_txd,
  input  logic       mii_tx_er,
  output logic       mii_tx_clk,
  output logic       rmii_tx_en,
  output logic [1:0] rmii_txd
);
  logic take_nibble;
  logic next_half;

  tx_slot_timer #(.SLOW_DIV(SLOW_DIV)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .slow        (rate_10m),
    .take_nibble (take_nibble),
    .next_half   (next_half),
    .txclk_q     (mii_tx_clk)
  );

  tx_dibit_shaper u_shaper (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_nibble (take_nibble),
    .next_half   (next_half),
    .tx_en       (mii_tx_en),
    .txd         (mii_txd),
    .tx_er       (mii_tx_er),
    .out_en      (rmii_tx_en),
    .out_d       (rmii_txd)
  );
endmodule

// File: rtl/mii_rmii_tx_bridge_chk.sv
module mii_rmii_tx_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rate_10m,
  input logic       mii_tx_en,
  input logic       mii_tx_er,
  input logic       mii_tx_clk,
  input logic       rmii_tx_en,
  input logic [1:0] rmii_txd
);
  AST_IDLE_DIBIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rmii_tx_en |-> rmii_txd == 2'b00); // R6

  AST_FAST_CLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !rate_10m && !$past(rate_10m)) |-> mii_tx_clk != $past(mii_tx_clk)); // R2

  AST_EN_AT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rmii_tx_en != $past(rmii_tx_en)) |-> $rose(mii_tx_clk)); // R5

  AST_DIBIT_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rmii_txd != $past(rmii_txd)) |-> mii_tx_clk != $past(mii_tx_clk)); // R3

  AST_ERR_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(mii_tx_clk) && $past(mii_tx_en) && $past(mii_tx_er)) |-> rmii_txd == 2'b01); // R7
endmodule

bind mii_rmii_tx_bridge mii_rmii_tx_bridge_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rate_10m   (rate_10m),
  .mii_tx_en  (mii_tx_en),
  .mii_tx_er  (mii_tx_er),
  .mii_tx_clk (mii_tx_clk),
  .rmii_tx_en (rmii_tx_en),
  .rmii_txd   (rmii_txd)
);

// File: tb/tb_mii_rmii_tx_bridge.sv
`timescale 1ns/1ps
module tb_mii_rmii_tx_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rate_10m = 1'b0;
  logic       mii_tx_en = 1'b0;
  logic [3:0] mii_txd = 4'h0;
  logic       mii_tx_er = 1'b0;
  logic       mii_tx_clk;
  logic       rmii_tx_en;
  logic [1:0] rmii_txd;

  int total = 0;
  int bad = 0;

  logic       m_en = 1'b0;
  logic [3:0] m_d = 4'h0;
  logic       m_er = 1'b0;
  logic       m_err = 1'b0;

  always #10 clk = ~clk;

  mii_rmii_tx_bridge dut (
    .clk(clk), .rst_n(rst_n), .rate_10m(rate_10m),
    .mii_tx_en(mii_tx_en), .mii_txd(mii_txd), .mii_tx_er(mii_tx_er),
    .mii_tx_clk(mii_tx_clk), .rmii_tx_en(rmii_tx_en), .rmii_txd(rmii_txd)
  );

  task automatic chk(input int act, input int exp, input string what, input string rq);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
    end
  endtask

  // Called just after a capture edge: drives the next nibble and checks the
  // period that shows the nibble captured at that edge.
  task automatic step(input logic en, input logic [3:0] d, input logic er, input string rq);
    logic [1:0] lo;
    logic [1:0] hi;
    logic       e_en;
    int         len;
    m_err = m_en ? (m_err | m_er) : 1'b0;
    e_en  = m_en;
    lo = !m_en ? 2'b00 : (m_err ? 2'b01 : m_d[1:0]);
    hi = !m_en ? 2'b00 : (m_err ? 2'b01 : m_d[3:2]);
    mii_tx_en = en; mii_txd = d; mii_tx_er = er;
    m_en = en; m_d = d; m_er = er;
    len = rate_10m ? 10 : 1;
    for (int k = 0; k < 2 * len; k++) begin
      @(negedge clk);
      chk(int'(rmii_txd), int'((k < len) ? lo : hi), "rmii_txd", rq);
      chk(int'(rmii_tx_en), int'(e_en), "rmii_tx_en R5", rq);
      chk(int'(mii_tx_clk), (k < len) ? 1 : 0, "mii_tx_clk", rate_10m ? "R3" : "R2");
    end
    @(posedge mii_tx_clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(int'(rmii_tx_en), 0, "reset en", "R1");
      chk(int'(rmii_txd), 0, "reset txd", "R1");
      chk(int'(mii_tx_clk), 0, "reset clk", "R1");
    end
    rst_n = 1'b1;
    @(posedge mii_tx_clk);
    #1;
  endtask

  task automatic t_fast_frame;
    step(1'b0, 4'h0, 1'b0, "R6");
    step(1'b1, 4'h5, 1'b0, "R6");
    step(1'b1, 4'hD, 1'b0, "R4");
    step(1'b1, 4'hA, 1'b0, "R4");
    step(1'b1, 4'h3, 1'b0, "R4");
    step(1'b1, 4'h6, 1'b0, "R4");
    step(1'b0, 4'hF, 1'b0, "R4");
    step(1'b0, 4'h0, 1'b0, "R6");
  endtask

  task automatic t_fast_error;
    step(1'b1, 4'hC, 1'b0, "R6");
    step(1'b1, 4'hE, 1'b1, "R4");
    step(1'b1, 4'h0, 1'b0, "R7");
    step(1'b1, 4'hF, 1'b0, "R7");
    step(1'b0, 4'h0, 1'b0, "R7");
    step(1'b1, 4'hB, 1'b0, "R8");
    step(1'b1, 4'h4, 1'b0, "R8");
    step(1'b0, 4'h0, 1'b0, "R8");
    step(1'b0, 4'h0, 1'b0, "R6");
  endtask

  task automatic t_er_idle;
    step(1'b0, 4'hF, 1'b1, "R6");
    step(1'b0, 4'hA, 1'b1, "R9");
    step(1'b1, 4'h9, 1'b0, "R9");
    step(1'b1, 4'h2, 1'b0, "R9");
    step(1'b0, 4'h0, 1'b0, "R9");
    step(1'b0, 4'h0, 1'b0, "R6");
  endtask

  task automatic t_slow;
    rate_10m = 1'b1;
    step(1'b1, 4'h7, 1'b0, "R10");
    step(1'b1, 4'hE, 1'b0, "R3");
    step(1'b1, 4'h1, 1'b1, "R3");
    step(1'b1, 4'hC, 1'b0, "R7");
    step(1'b0, 4'h0, 1'b0, "R7");
    step(1'b1, 4'h9, 1'b0, "R8");
    step(1'b0, 4'h0, 1'b0, "R8");
    step(1'b0, 4'h0, 1'b0, "R6");
    rate_10m = 1'b0;
    step(1'b1, 4'h8, 1'b0, "R10");
    step(1'b0, 4'h0, 1'b0, "R10");
    step(1'b0, 4'h0, 1'b0, "R10");
  endtask

  initial begin
    t_reset();
    t_fast_frame();
    t_fast_error();
    t_er_idle();
    t_slow();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule